// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host places a byte in a one-deep holding register with a write strobe. A serializer then sends it as a frame: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then 1, 1.5 or 2 high stop bits. All timing is counted in pulses of a 16x oversampling tick. The holding register is separate from the serializer. The host can therefore queue the next byte while the current one is being sent, and consecutive frames follow with no idle gap.

The block reports when the holding register is empty. It raises an interrupt request while the register is empty and the interrupt is enabled. It also drives a request-to-send level that the host sets. The frame format inputs are sampled once, when a byte moves from the holding register into the serializer. The serializer state machine has five states:
- `S_IDLE`: the line is high.
- `S_START`: the start bit.
- `S_DATA`: the data bits.
- `S_PARITY`: the parity bit.
- `S_STOP`: the stop bits.

Its transitions are:
- load: `S_IDLE`→`S_START`, on a tick while the holding register is full.
- start-done: `S_START`→`S_DATA`.
- data-done: `S_DATA`→`S_PARITY`, or `S_DATA`→`S_STOP` when parity is off.
- parity-done: `S_PARITY`→`S_STOP`.
- chain: `S_STOP`→`S_START`, at the end of the stop time when a byte is waiting.
- drain: `S_STOP`→`S_IDLE`, at the end of the stop time when no byte is waiting.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx` is 1 and `thr_empty` is 1.
- R2: A frame starts with `tx`=0 for 16 ticks. The data bits follow, least significant bit first, each held for 16 ticks. The number of data bits is 5, 6, 7 or 8 for `word_len` codes 00, 01, 10 and 11.
- R3: With `par_en`=1, one parity bit of 16 ticks follows the data bits. With `par_odd`=0 the count of ones across the data bits and the parity bit is even; with `par_odd`=1 it is odd. With `par_en`=0 no parity bit is sent.
- R4: The stop time is `tx`=1 for 16 ticks when `stop_sel`=00, and for 32 ticks when `stop_sel` is 10 or 11.
- R5: `stop_sel`=01 gives a stop time of 24 ticks, which is one and a half bit times.
- R6: The format inputs are sampled when a byte enters the serializer. Changing them during a frame does not change that frame.
- R7: A write makes `thr_empty` 0 from the next cycle on. A byte is transferred on the first tick after the write when the line is idle, or on the last tick of the stop time when a frame is running. The transfer sets `thr_empty` to 1, and the next frame's start bit begins with no idle gap.
- R8: A write in the same cycle as a transfer stores the new byte, keeps `thr_empty` at 0, and the byte that was already held is the one sent.
- R9: A write while the holding register is full replaces the held byte, and only the newer byte is sent.
- R10: `irq` is 1 exactly while `irq_en` is 1 and `thr_empty` is 1.
- R11: `rts_o` follows `rts_req` one cycle later.
- R12: `tx` changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to store |
| word_len | input | 2 | Data bit count code: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | Stop time code: 00=1 bit, 01=1.5 bits, 1x=2 bits |
| irq_en | input | 1 | Interrupt enable |
| rts_req | input | 1 | Requested request-to-send level |
| tx | output | 1 | Serial output line, idles high |
| thr_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| rts_o | output | 1 | Registered request-to-send level |

## Verification
The host write and the transfer from the holding register into the serializer can fall in the same clock edge. The write refills the register while the transfer empties it. The bench provokes this by watching its own reference model. It fills the holding register and then waits for the edge where the model's frame has one tick left and the tick input is high, and it issues the write there. The expected outcome is that the older byte goes out in the next frame and the flag stays low, since the register is still full, and that the newer byte follows as the frame after that. Both are judged tick by tick against the line levels the model predicts.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP   = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_bit;
        logic [1:0] stop;
    } frame_cfg_t;

endpackage

// File: rtl/uft_hold_reg.sv
module uft_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);

    // a write in the same cycle as a take wins: the new byte stays held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
        end else if (wr_en) begin
            hold_data <= wr_data;
        end
    end

endmodule

// File: rtl/uft_slot_cnt.sv
module uft_slot_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    assign done = run && tick && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            if (done) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/uft_frame_fsm.sv
module uft_frame_fsm
    import uft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              slot_done,
    output logic              frame_load,
    output logic              run,
    output logic [CNT_W-1:0]  slot_len,
    output logic              tx_line
);

    localparam int               IDX_W     = $clog2(DATA_W);
    localparam int               MIN_BITS  = 5;
    localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] LEN_3HALF = CNT_W'(OVS + OVS / 2);
    localparam logic [CNT_W-1:0] LEN_TWO   = CNT_W'(2 * OVS);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  bit_idx_q;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] len_mask;
    logic              par_calc;
    logic              last_bit;
    logic              may_chain;
    logic [CNT_W-1:0]  stop_len;

    // mask of the data bits that belong to the selected word length
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            len_mask[i] = (i < MIN_BITS + int'(word_len));
        end
    end

    assign par_calc  = (^(hold_data & len_mask)) ^ par_odd;
    assign last_bit  = (bit_idx_q == IDX_W'(MIN_BITS - 1 + int'(cfg_q.len)));
    assign may_chain = (state_q == S_IDLE) || ((state_q == S_STOP) && slot_done);

    // a transfer takes place on a tick while idle, or at the last stop tick
    assign frame_load = tick && hold_full && may_chain;

    always_comb begin
        unique case (cfg_q.stop)
            2'b00:   stop_len = LEN_ONE;
            2'b01:   stop_len = LEN_3HALF;
            default: stop_len = LEN_TWO;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (frame_load) state_d = S_START;
            end
            S_START: begin
                if (slot_done) state_d = S_DATA;
            end
            S_DATA: begin
                if (slot_done && last_bit) begin
                    state_d = cfg_q.par_en ? S_PARITY : S_STOP;
                end
            end
            S_PARITY: begin
                if (slot_done) state_d = S_STOP;
            end
            S_STOP: begin
                if (slot_done) state_d = frame_load ? S_START : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // frame datapath: serializer, bit index and sampled format
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_idx_q <= '0;
            cfg_q     <= '0;
        end else if (frame_load) begin
            shift_q       <= hold_data;
            bit_idx_q     <= '0;
            cfg_q.len     <= word_len;
            cfg_q.par_en  <= par_en;
            cfg_q.par_bit <= par_calc;
            cfg_q.stop    <= stop_sel;
        end else if ((state_q == S_DATA) && slot_done) begin
            shift_q   <= shift_q >> 1;
            bit_idx_q <= bit_idx_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        tx_line  = 1'b1;
        run      = 1'b1;
        slot_len = LEN_ONE;
        unique case (state_q)
            S_IDLE: begin
                run = 1'b0;
            end
            S_START: begin
                tx_line = 1'b0;
            end
            S_DATA: begin
                tx_line = shift_q[0];
            end
            S_PARITY: begin
                tx_line = cfg_q.par_bit;
            end
            S_STOP: begin
                slot_len = stop_len;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              irq_en,
    input  logic              rts_req,
    output logic              tx,
    output logic              thr_empty,
    output logic              irq,
    output logic              rts_o
);

    localparam int CNT_W = $clog2(2 * OVS + 1);

    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              frame_load;
    logic              slot_run;
    logic              slot_done;
    logic [CNT_W-1:0]  slot_len;
    logic [CNT_W-1:0]  slot_cnt;

    uft_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (frame_load),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    uft_slot_cnt #(
        .CNT_W (CNT_W)
    ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (slot_run),
        .tick  (tick16),
        .limit (slot_len),
        .cnt   (slot_cnt),
        .done  (slot_done)
    );

    uft_frame_fsm #(
        .DATA_W (DATA_W),
        .OVS    (OVS),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .word_len   (word_len),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .stop_sel   (stop_sel),
        .slot_done  (slot_done),
        .frame_load (frame_load),
        .run        (slot_run),
        .slot_len   (slot_len),
        .tx_line    (tx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_o <= 1'b0;
        end else begin
            rts_o <= rts_req;
        end
    end

    assign thr_empty = ~hold_full;
    assign irq       = irq_en & thr_empty;

endmodule

// File: rtl/uft_props.sv
module uft_props #(
    parameter int OVS   = 16,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick16,
    input logic             wr_en,
    input logic             tx,
    input logic             thr_empty,
    input logic             irq,
    input logic             irq_en,
    input logic             rts_req,
    input logic             rts_o,
    input logic             frame_load,
    input logic [CNT_W-1:0] slot_cnt
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assert_rts_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (rts_o == $past(rts_req)));

    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !thr_empty);

    assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_load && !wr_en) |=> thr_empty);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> thr_empty);

    assert_tx_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(tick16)) |-> $stable(tx));

    assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt <= CNT_W'(2 * OVS - 1));

endmodule

bind uart_frame_tx uft_props #(
    .OVS   (OVS),
    .CNT_W (CNT_W)
) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .wr_en      (wr_en),
    .tx         (tx),
    .thr_empty  (thr_empty),
    .irq        (irq),
    .irq_en     (irq_en),
    .rts_req    (rts_req),
    .rts_o      (rts_o),
    .frame_load (frame_load),
    .slot_cnt   (slot_cnt)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

    localparam int OVS      = 16;
    localparam int TICK_DIV = 3;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       tick16   = 1'b0;
    logic       wr_en    = 1'b0;
    logic [7:0] wr_data  = 8'h00;
    logic [1:0] word_len = 2'b11;
    logic       par_en   = 1'b0;
    logic       par_odd  = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       irq_en   = 1'b0;
    logic       rts_req  = 1'b0;
    logic       tx;
    logic       thr_empty;
    logic       irq;
    logic       rts_o;

    uart_frame_tx #(.DATA_W(8), .OVS(OVS)) i_uart_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_sel  (stop_sel),
        .irq_en    (irq_en),
        .rts_req   (rts_req),
        .tx        (tx),
        .thr_empty (thr_empty),
        .irq       (irq),
        .rts_o     (rts_o)
    );

    always #10 clk = ~clk;

    int    n_chk   = 0;
    int    n_fail  = 0;
    int    div     = 0;
    bit    started = 1'b0;
    string note    = "";

    // reference model: one queue entry per tick of the frame in flight
    bit         lvl_q[$];
    string      tag_q[$];
    bit         m_full    = 1'b0;
    logic [7:0] m_hold    = 8'h00;
    bit         m_rts     = 1'b0;
    bit         last_tick = 1'b0;
    bit         ld;
    logic       tx_prev   = 1'b1;

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void push(input bit lvl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            lvl_q.push_back(lvl);
            tag_q.push_back(tag);
        end
    endfunction

    function automatic void build(input logic [7:0] d);
        int nb = 5 + int'(word_len);
        bit p  = par_odd;
        push(1'b0, OVS, "R2");
        for (int i = 0; i < nb; i++) begin
            push(d[i], OVS, "R2");
            p = p ^ d[i];
        end
        if (par_en) push(p, OVS, "R3");
        if (stop_sel == 2'b00)      push(1'b1, OVS, "R4");
        else if (stop_sel == 2'b01) push(1'b1, OVS + OVS / 2, "R5");
        else                        push(1'b1, 2 * OVS, "R4");
    endfunction

    always @(negedge clk) begin
        div = (div == TICK_DIV - 1) ? 0 : div + 1;
        tick16 <= (div == 0);
    end

    always @(posedge clk) begin
        last_tick = tick16;
        if (!rst_n) begin
            lvl_q.delete();
            tag_q.delete();
            m_full = 1'b0;
            m_hold = 8'h00;
            m_rts  = 1'b0;
        end else begin
            ld = 1'b0;
            if (tick16) begin
                if (lvl_q.size() == 0) begin
                    ld = m_full;
                end else begin
                    void'(lvl_q.pop_front());
                    void'(tag_q.pop_front());
                    if (lvl_q.size() == 0) ld = m_full;
                end
            end
            if (ld) begin
                build(m_hold);
                m_full = 1'b0;
            end
            if (wr_en) begin
                m_hold = wr_data;
                m_full = 1'b1;
            end
            m_rts = rts_req;
        end
    end

    always @(negedge clk) begin
        if (rst_n && started) begin
            logic  exp_tx;
            string tag;
            exp_tx = (lvl_q.size() != 0) ? lvl_q[0] : 1'b1;
            tag    = (lvl_q.size() != 0) ? tag_q[0] : "R1";
            check(tx === exp_tx, {tag, note}, {7'b0, tx}, {7'b0, exp_tx});
            check(thr_empty === !m_full, {"R7", note}, {7'b0, thr_empty}, {7'b0, !m_full});
            check(irq === (irq_en && !m_full), "R10", {7'b0, irq}, {7'b0, irq_en && !m_full});
            check(rts_o === m_rts, "R11", {7'b0, rts_o}, {7'b0, m_rts});
            if (!last_tick) check(tx === tx_prev, "R12", {7'b0, tx}, {7'b0, tx_prev});
            tx_prev = tx;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic wait_done();
        while (m_full || lvl_q.size() != 0) step();
    endtask

    task automatic wait_taken();
        while (m_full) step();
    endtask

    initial begin
        repeat (4) step();
        // R1: reset values
        check(tx === 1'b1, "R1", {7'b0, tx}, 8'h01);
        check(thr_empty === 1'b1, "R1", {7'b0, thr_empty}, 8'h01);
        rst_n   = 1'b1;
        started = 1'b1;
        repeat (3) step();

        // R2 R3 R4 R5: sweep every format
        irq_en = 1'b1;
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ss = 0; ss < 4; ss++) begin
                    word_len = 2'(wl);
                    par_en   = (pm != 0);
                    par_odd  = (pm == 2);
                    stop_sel = 2'(ss);
                    write(8'hA5 ^ 8'(wl * 37 + pm * 11 + ss * 3));
                    wait_done();
                    repeat (5) step();
                end
            end
        end

        // R6: format change in the middle of a frame
        note = " R6";
        word_len = 2'b11; par_en = 1'b1; par_odd = 1'b0; stop_sel = 2'b01;
        write(8'h3C);
        repeat (60) step();
        word_len = 2'b00; par_en = 1'b0; stop_sel = 2'b10;
        wait_done();
        note = "";

        // R7: back-to-back frames
        word_len = 2'b11; par_en = 1'b0; stop_sel = 2'b00;
        write(8'h81);
        wait_taken();
        write(8'h7E);
        wait_done();

        // R8: write on the same edge as the transfer
        note = " R8";
        write(8'h11);
        wait_taken();
        write(8'h22);
        while (!(tick16 && lvl_q.size() == 1)) step();
        write(8'h33);
        wait_done();

        // R9: overwrite while full
        note = " R9";
        write(8'h44);
        wait_taken();
        write(8'h55);
        write(8'h66);
        wait_done();
        note = "";

        // R10: interrupt mask
        irq_en = 1'b0;
        repeat (4) step();
        write(8'h99);
        repeat (10) step();
        irq_en = 1'b1;
        wait_done();
        repeat (4) step();
        irq_en = 1'b0;
        repeat (4) step();

        // R11: request-to-send level
        for (int r = 0; r < 6; r++) begin
            rts_req = r[0];
            repeat (r + 1) step();
        end
        repeat (5) step();
        finish_run();
    end

endmodule